// File: doc/BRIEF.md
# In-Place Single-Bit Word-Row Rotator

This block turns a long bit row by one position while the row stays in a synchronous single-port RAM, stored as consecutive words of `WORD_W` bits. The RAM is read-before-write: in a cycle where the block presents an address with the write enable high, the RAM returns the old content of that cell on the next cycle and stores the new word. One carry flip-flop per lane moves the bit that crosses from each word into the next. The block makes one pass over the row, so the RAM needs no second port and no scratch buffer.

Because every rotated word is written one cell further on than the cell it came from, the whole row also shifts up by one cell on each pass. The block keeps a base pointer, the cell that now holds the row's most significant word, and puts it on a port so that other logic can address the row. Several lanes, two by default, share the address and the sequencing. Each lane rotates its own row with its own carry, using a separate data slice of the same RAM address.

The RAM sits outside the block. The block drives the address, write enable and write data, and takes the read data one cycle after the address.

Top module: `bitrow_rotator`

## Requirements
- R1: After a synchronous active-high reset, `done` is low, `mem_we` is low and `base_cell` is 0.
- R2: A `start` pulse is accepted only while the block is idle and `row_bits` lies in 1..`MAX_BITS`. A start that arrives during a rotation, or with a length outside that range, changes no address, write, `done` or `base_cell` value and no RAM word.
- R3: Let r be the row length and W = ceil(r/WORD_W). In the first cycle after a start is accepted, the block addresses the cell of logical word W-1, which is cell (base+W-1) mod W. In the second cycle it addresses the base cell. The write enable is low in both cycles.
- R4: Logical word j is kept in cell (base+j) mod W. Word 0 holds row bits r-1 down to r-WORD_W, with the MSB of the row in the word's MSB. From the third cycle on, the block addresses cells (base+1), (base+2), … mod W with the write enable high. In each of these cycles it writes the word read in the cycle before, shifted right by one, and the MSB of that written word is the bit that dropped out of the word before it. At the end of the pass, new row bit i equals old bit i+1, and new bit r-1 equals old bit 0.
- R5: The last word holds its row bits in its upper positions, and its low 32·W−r (pad) bits are zero. The row wraps at bit r: the bit taken into the carry first is the bit just above the pad, and the pad bits are written back as zero.
- R6: A pass keeps the RAM port busy for exactly W+2 cycles. `done` is high for exactly one cycle, the cycle after the final write, which is W+2 cycles after the first cycle of the pass.
- R7: `base_cell` changes to (base+1) mod W in the same cycle that `done` goes high, and otherwise holds its value.
- R8: All lanes share the address and the write enable. Each lane has its own carry, and each lane's row turns by one bit independently of the data in the other lanes.
- R9: If an accepted start carries a `row_bits` value different from the one last latched, the pass treats the base as cell 0. The RAM is then assumed to hold the new row at cell 0.
- R10: A row of one word (r ≤ WORD_W, with or without pad bits) rotates correctly in place, and its base stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one single-bit rotation |
| row_bits | input | bits_for(MAX_BITS) | Row length r in bits, sampled with start |
| done | output | 1 | One-cycle pulse when a pass has finished |
| base_cell | output | bits_for(MAX_WORDS-1) | Cell that holds the row's most significant word |
| mem_addr | output | bits_for(MAX_WORDS-1) | RAM address shared by all lanes |
| mem_we | output | 1 | RAM write enable (read-before-write at the same address) |
| mem_wdata | output | LANES*WORD_W | Write data, lane k in bits [k*WORD_W +: WORD_W] |
| mem_rdata | input | LANES*WORD_W | Read data, one cycle after the address |

## Verification
A wrong base pointer or a wrong address step shows up in the very next cycle as an address that differs from the mod-W sequence the bench expects. A bad carry or a bad pad mask stays hidden until the pass ends, and then appears as a wrong RAM word when the bench compares every cell against a rotated copy of the row that it keeps itself. A stray write outside the row's W cells overwrites a sentinel word. A start that should have been ignored shifts the later address trace or moves `done` by more than one cycle.

// File: rtl/brot_pkg.sv
package brot_pkg;

    // Sequencing phases of one rotation pass
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FETCH,   // address last word, capture wrap bit next cycle
        PH_LOAD,    // address word 0, no write
        PH_STREAM,  // read next word, write rotated previous word
        PH_FLUSH    // write rotated last word into the base cell
    } phase_e;

    // Per-lane control from the sequencer
    typedef struct packed {
        logic seed;   // rdata holds last word: take the wrap bit
        logic shift;  // rdata holds a row word: shift it out
        logic last;   // word being written is the last (pad mask)
    } lane_ctl_t;

    // Smallest width able to hold values 0..v
    function automatic int bits_for(input int v);
        int w;
        w = 1;
        while ((1 << w) <= v) w++;
        return w;
    endfunction

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/brot_lane.sv
module brot_lane
    import brot_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int PW     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  lane_ctl_t         ctl_i,
    input  logic [PW-1:0]     pad_i,
    input  logic [WORD_W-1:0] rdata_i,
    output logic [WORD_W-1:0] wdata_o
);
    logic              carry_q;
    logic [WORD_W-1:0] shifted;
    logic [WORD_W-1:0] keep_mask;

    always_comb begin
        shifted   = {carry_q, rdata_i[WORD_W-1:1]};
        keep_mask = {WORD_W{1'b1}} << pad_i;
        wdata_o   = ctl_i.last ? (shifted & keep_mask) : shifted;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q <= 1'b0;
        end else if (ctl_i.seed) begin
            carry_q <= rdata_i[pad_i];
        end else if (ctl_i.shift) begin
            carry_q <= rdata_i[0];
        end
    end

    // R4
    msb_link_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.shift && $past(ctl_i.shift)) |-> (wdata_o[WORD_W-1] == $past(rdata_i[0])));

    // R5
    wrap_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.shift && $past(ctl_i.seed)) |-> (wdata_o[WORD_W-1] == $past(rdata_i[pad_i])));

endmodule

// File: rtl/brot_ctrl.sv
module brot_ctrl
    import brot_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int MAX_BITS = 4801,
    parameter int AW       = 8,
    parameter int CW       = 8,
    parameter int LW       = 13,
    parameter int PW       = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [LW-1:0] row_bits_i,
    output logic [AW-1:0] addr_o,
    output logic          we_o,
    output lane_ctl_t     lane_ctl_o,
    output logic [PW-1:0] pad_o,
    output logic          done_o,
    output logic [AW-1:0] base_o
);
    phase_e        phase_q;
    logic [LW-1:0] len_q;
    logic [CW-1:0] nw_q, nw_new, cnt_q;
    logic [PW-1:0] pad_q, pad_new;
    logic [AW-1:0] base_q, base_eff, base_next, ptr_q, ptr_next, ptr_first;
    logic          done_q, accept;

    always_comb begin
        accept    = (phase_q == PH_IDLE) && start_i && (row_bits_i != '0)
                    && (int'(row_bits_i) <= MAX_BITS);
        nw_new    = CW'(ceil_div(int'(row_bits_i), WORD_W));
        pad_new   = PW'(int'(nw_new) * WORD_W - int'(row_bits_i));
        base_eff  = (row_bits_i == len_q) ? base_q : '0;
        ptr_first = (base_eff == '0) ? AW'(int'(nw_new) - 1) : base_eff - AW'(1);
        ptr_next  = (int'(ptr_q) == int'(nw_q) - 1) ? '0 : ptr_q + AW'(1);
        base_next = (int'(base_q) == int'(nw_q) - 1) ? '0 : base_q + AW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            len_q   <= '0;
            nw_q    <= '0;
            pad_q   <= '0;
            base_q  <= '0;
            ptr_q   <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        len_q   <= row_bits_i;
                        nw_q    <= nw_new;
                        pad_q   <= pad_new;
                        base_q  <= base_eff;
                        ptr_q   <= ptr_first;
                        phase_q <= PH_FETCH;
                    end
                end
                PH_FETCH: begin
                    ptr_q   <= base_q;
                    phase_q <= PH_LOAD;
                end
                PH_LOAD: begin
                    ptr_q   <= ptr_next;
                    cnt_q   <= CW'(1);
                    phase_q <= (int'(nw_q) == 1) ? PH_FLUSH : PH_STREAM;
                end
                PH_STREAM: begin
                    ptr_q <= ptr_next;
                    cnt_q <= cnt_q + CW'(1);
                    if (int'(cnt_q) == int'(nw_q) - 1) phase_q <= PH_FLUSH;
                end
                PH_FLUSH: begin
                    phase_q <= PH_IDLE;
                    done_q  <= 1'b1;
                    base_q  <= base_next;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        addr_o           = ptr_q;
        we_o             = (phase_q == PH_STREAM) || (phase_q == PH_FLUSH);
        lane_ctl_o.seed  = (phase_q == PH_LOAD);
        lane_ctl_o.shift = we_o;
        lane_ctl_o.last  = (phase_q == PH_FLUSH);
        pad_o            = pad_q;
        done_o           = done_q;
        base_o           = base_q;
    end

    // Cycle counter used only by the latency check
    logic [CW+1:0] lat_q;
    always_ff @(posedge clk) begin
        if (rst)                    lat_q <= '0;
        else if (accept)            lat_q <= '0;
        else if (phase_q != PH_IDLE) lat_q <= lat_q + (CW+2)'(1);
    end

    // R3
    fetch_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !we_o);

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (we_o && $past(we_o)) |-> (int'(addr_o) == (int'($past(addr_o)) + 1) % int'(nw_q)));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6
    pass_len_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (int'(lat_q) == int'(nw_q) + 2));

    // R7
    base_step_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (int'(base_o) == (int'($past(base_o)) + 1) % int'(nw_q)));

    // R7
    base_range_chk: assert property (@(posedge clk) disable iff (rst)
        (nw_q != '0) |-> (int'(base_o) < int'(nw_q)));

endmodule

// File: rtl/bitrow_rotator.sv
module bitrow_rotator
    import brot_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int MAX_BITS = 4801,
    parameter int LANES    = 2
) (
    input  logic                                                   clk,
    input  logic                                                   rst,
    input  logic                                                   start,
    input  logic [bits_for(MAX_BITS)-1:0]                          row_bits,
    output logic                                                   done,
    output logic [bits_for(ceil_div(MAX_BITS, WORD_W) - 1)-1:0]    base_cell,
    output logic [bits_for(ceil_div(MAX_BITS, WORD_W) - 1)-1:0]    mem_addr,
    output logic                                                   mem_we,
    output logic [LANES*WORD_W-1:0]                                mem_wdata,
    input  logic [LANES*WORD_W-1:0]                                mem_rdata
);
    localparam int MAX_WORDS = ceil_div(MAX_BITS, WORD_W);
    localparam int AW        = bits_for(MAX_WORDS - 1);
    localparam int CW        = bits_for(MAX_WORDS);
    localparam int LW        = bits_for(MAX_BITS);
    localparam int PW        = bits_for(WORD_W - 1);

    lane_ctl_t     lane_ctl;
    logic [PW-1:0] pad;

    brot_ctrl #(
        .WORD_W  (WORD_W),
        .MAX_BITS(MAX_BITS),
        .AW      (AW),
        .CW      (CW),
        .LW      (LW),
        .PW      (PW)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .row_bits_i(row_bits),
        .addr_o    (mem_addr),
        .we_o      (mem_we),
        .lane_ctl_o(lane_ctl),
        .pad_o     (pad),
        .done_o    (done),
        .base_o    (base_cell)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        brot_lane #(
            .WORD_W(WORD_W),
            .PW    (PW)
        ) u_lane (
            .clk    (clk),
            .rst    (rst),
            .ctl_i  (lane_ctl),
            .pad_i  (pad),
            .rdata_i(mem_rdata[g*WORD_W +: WORD_W]),
            .wdata_o(mem_wdata[g*WORD_W +: WORD_W])
        );
    end

endmodule

// File: tb/bitrow_rotator_test.sv
`timescale 1ns/1ps
module bitrow_rotator_test;
    localparam int WW = 32;
    localparam int MB = 4801;
    localparam int NL = 2;
    localparam int MW = (MB + WW - 1) / WW;
    localparam int AW = brot_pkg::bits_for(MW - 1);
    localparam int LW = brot_pkg::bits_for(MB);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [LW-1:0]     row_bits = '0;
    logic              done;
    logic [AW-1:0]     base_cell, mem_addr;
    logic              mem_we;
    logic [NL*WW-1:0]  mem_wdata;
    logic [NL*WW-1:0]  mem_rdata = '0;

    logic [WW-1:0] ram [NL][MW];
    bit            rowb [NL][MB];
    int cur_len, cur_w, cur_base;
    int compared = 0, mismatched = 0;
    bit finished = 0;

    bitrow_rotator #(.WORD_W(WW), .MAX_BITS(MB), .LANES(NL)) uut (
        .clk(clk), .rst(rst), .start(start), .row_bits(row_bits), .done(done),
        .base_cell(base_cell), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #2 clk = ~clk;

    // Read-before-write single-port RAM model
    always @(posedge clk) begin
        if (int'(mem_addr) < MW) begin
            for (int l = 0; l < NL; l++) begin
                mem_rdata[l*WW +: WW] <= ram[l][mem_addr];
                if (mem_we) ram[l][mem_addr] <= mem_wdata[l*WW +: WW];
            end
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] pack_word(input int l, input int j);
        logic [WW-1:0] w;
        w = '0;
        for (int p = 0; p < WW; p++) begin
            int idx;
            idx = cur_len - WW - WW * j + p;
            if (idx >= 0) w[p] = rowb[l][idx];
        end
        return w;
    endfunction

    function automatic logic [WW-1:0] sentinel(input int l, input int c);
        return 32'hA5C3_0000 | WW'(c) | (WW'(l) << 12);
    endfunction

    task automatic load_row(input int len, input int kind);
        cur_len  = len;
        cur_w    = (len + WW - 1) / WW;
        cur_base = 0;
        for (int l = 0; l < NL; l++)
            for (int i = 0; i < MB; i++)
                rowb[l][i] = (i < len) &&
                    ((kind == 0) ? (($urandom % 53) == 0) :
                     (kind == 1) ? ((i % (l + 3)) == 0) : ($urandom % 2 == 1));
        if (len > 1) begin
            rowb[0][0] = 1'b1;        // bit that wraps on the first pass
            rowb[1][len - 1] = 1'b1;  // MSB set on the other lane
        end
        for (int l = 0; l < NL; l++)
            for (int c = 0; c < MW; c++)
                ram[l][c] = (c < cur_w) ? pack_word(l, c) : sentinel(l, c);
    endtask

    task automatic verify_mem(input string req);
        for (int l = 0; l < NL; l++)
            for (int c = 0; c < MW; c++)
                check(req, ram[l][c],
                      (c < cur_w) ? pack_word(l, (c - cur_base + cur_w) % cur_w)
                                  : sentinel(l, c));
    endtask

    // One pass; poke_k >= 0 fires an extra start during that busy cycle
    task automatic rotate(input int poke_k, input string tag);
        int w, b;
        w = cur_w;
        b = cur_base;
        @(negedge clk);
        start = 1'b1;
        row_bits = LW'(cur_len);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= w + 3; k++) begin
            if (k <= w + 1) begin
                check({"R3 R4 R9 addr ", tag}, mem_addr, (k == 0) ? (b + w - 1) % w : (b + k - 1) % w);
                check({"R3 R4 we ", tag}, mem_we, (k >= 2));
            end else begin
                check({"R6 we idle ", tag}, mem_we, 0);
            end
            check({"R6 done ", tag}, done, (k == w + 2));
            check({"R7 base ", tag}, base_cell, (k >= w + 2) ? (b + 1) % w : b);
            if (k == poke_k) begin
                start = 1'b1;
                row_bits = LW'((cur_len == 33) ? 64 : 33);  // R2 busy start
            end
            @(negedge clk);
            start = 1'b0;
            row_bits = LW'(cur_len);
        end
        for (int l = 0; l < NL; l++) begin
            bit t;
            t = rowb[l][0];
            for (int i = 0; i < cur_len - 1; i++) rowb[l][i] = rowb[l][i + 1];
            rowb[l][cur_len - 1] = t;
        end
        cur_base = (b + 1) % w;
        verify_mem({"R4 R5 R8 mem ", tag});
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 done", done, 0);
        check("R1 we", mem_we, 0);
        check("R1 base", base_cell, 0);

        load_row(4801, 0);
        rotate(-1, "long");
        rotate(7, "long busy");      // R2
        rotate(150, "long busy late");

        // R2: zero and oversize lengths are not accepted
        @(negedge clk);
        start = 1'b1;
        row_bits = '0;
        @(negedge clk);
        row_bits = LW'(MB + 1);
        @(negedge clk);
        start = 1'b0;
        row_bits = LW'(cur_len);
        for (int k = 0; k < 4; k++) begin
            check("R2 bad len we", mem_we, 0);
            check("R2 bad len done", done, 0);
            check("R2 bad len base", base_cell, 3);
            @(negedge clk);
        end
        verify_mem("R2 bad len mem");
        rotate(-1, "long after bad");

        load_row(33, 2);             // R9 new length, base back to 0
        rotate(0, "pad31");
        rotate(-1, "pad31 again");

        load_row(32, 2);             // R10
        rotate(-1, "one word");
        rotate(1, "one word busy");

        load_row(1, 1);              // R10 single bit
        rotate(-1, "one bit");

        load_row(64, 2);
        rotate(-1, "two words");
        rotate(-1, "two words");
        rotate(-1, "two words");

        load_row(100, 1);
        rotate(-1, "pad28");
        rotate(2, "pad28 busy");

        load_row(4801, 2);           // R9 long row again
        rotate(-1, "long reload");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule